// File: doc/BRIEF.md
# Byte-Wide SPI Master with Transmit and Receive Queues

This block is an SPI bus master that a processor drives through four word-wide registers. Software sets the bus timing and the device-select pattern in a configuration register and starts the core through a separate enable register. It then writes bytes into a transmit queue. The shift engine drains that queue one byte at a time, most significant bit first. For every byte it drives out, it collects exactly one byte from the bus into a receive queue, which software empties by reading.

The serial clock is the reference clock divided by a power of two. Clock polarity, clock phase and the divisor reach the shift engine only while the core is disabled. They are frozen once it is enabled, so reprogramming them mid-stream cannot distort the serial clock. The four active-low select lines carry a software-written pattern. The pattern is either forced onto the pins at all times or applied only while the engine has work. A manual mode holds queued bytes back until software writes a self-clearing start bit.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, the configuration register reads 0x0000_3C09: master enable set, divisor code 1, select field all ones, every other field zero. The enable register reads 0, `ss_n` is 4'hF and `sclk` is 0.
- R2: Register offsets are 0x0 (configuration), 0x4 (enable, bit 0), 0x8 (transmit data, write only) and 0xC (receive data, read only). In the configuration word: bit 0 is master enable, bit 1 is polarity, bit 2 is phase, bits 5:3 are the divisor code, bit 9 is the decoded-select flag, bits 13:10 are the select field, bit 14 is force select, bit 15 is manual start enable and bit 16 is manual start. Every field except bit 16 reads back as written.
- R3: Each byte is shifted out MSB first as 8 bits on `mosi`. Each byte shifted out yields exactly one received byte, which is queued in order of arrival.
- R4: With phase 0, both ends sample on the first (leading) edge of each bit, and `mosi` changes on the trailing edge. With phase 1, `mosi` changes on the leading edge and both ends sample on the trailing edge. Polarity 1 inverts the idle level and the edge directions.
- R5: One `sclk` period lasts (2 << n) reference cycles for divisor code n from 1 to 7. Code 0 acts as code 1.
- R6: Polarity, phase and divisor are taken from the configuration register only while the core is disabled. Changing them while enabled has no effect on `sclk` until the next disable. While disabled, `sclk` sits at the configured polarity.
- R7: The transmit queue holds 128 bytes. A write to a full queue is dropped.
- R8: A read of receive data pops the oldest byte. When the queue is empty, the read returns 0.
- R9: Bytes move only while both enable bit 0 and master enable are 1.
- R10: With manual start enabled, queued bytes wait until a configuration write sets bit 16. That bit reads back as 0, and the permission lasts until the transmit queue has drained. With manual start disabled, a non-empty queue starts at once.
- R11: With force select set, `ss_n` equals the select field at all times. With force select clear, `ss_n` equals the field while a byte is shifting or the engine may start one, and reads 4'hF otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rd | input | 1 | Register read strobe (pops receive data at offset 0xC) |
| bus_rdata | output | 32 | Register read data, valid in the strobe cycle |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the devices |
| miso | input | 1 | Serial data from the devices |
| ss_n | output | 4 | Active-low device-select lines |

## Verification
A device model in the bench follows all four polarity/phase pairings with random bytes and random divisor codes. It records what it sees on `mosi` and answers with a computed byte stream. A swapped edge, a reversed bit order or a lost bit shows up as a mismatch on one side or the other. Divisor codes 0, 1, 3 and 7 are timed between consecutive leading edges, which separates the clamp at code 0 from an off-by-one in the power of two. Directed cases fill the transmit queue past its depth, read an empty receive queue, flip the polarity while enabled, hold bytes under manual start and clear master enable. Each case observes only the pins and register reads that the faulty variant would change.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

   localparam logic [3:0] ADDR_CFG = 4'h0;
   localparam logic [3:0] ADDR_EN  = 4'h4;
   localparam logic [3:0] ADDR_TX  = 4'h8;
   localparam logic [3:0] ADDR_RX  = 4'hC;

   localparam int CB_MST    = 0;
   localparam int CB_CPOL   = 1;
   localparam int CB_CPHA   = 2;
   localparam int CB_DIV_LO = 3;
   localparam int CB_DEC    = 9;
   localparam int CB_SEL_LO = 10;
   localparam int CB_FORCE  = 14;
   localparam int CB_MAN_EN = 15;
   localparam int CB_MAN_GO = 16;

   typedef struct packed {
      logic       man_en;
      logic       force_ss;
      logic [3:0] sel;
      logic       dec;
      logic [2:0] div;
      logic       cpha;
      logic       cpol;
      logic       mst;
   } cfg_t;

   typedef enum logic {ENG_IDLE, ENG_XFER} eng_state_t;

   localparam cfg_t CFG_RESET = '{man_en: 1'b0, force_ss: 1'b0, sel: 4'hF,
                                  dec: 1'b0, div: 3'd1, cpha: 1'b0,
                                  cpol: 1'b0, mst: 1'b1};

   function automatic cfg_t cfg_unpack(input logic [31:0] w);
      cfg_t c;
      c.mst      = w[CB_MST];
      c.cpol     = w[CB_CPOL];
      c.cpha     = w[CB_CPHA];
      c.div      = w[CB_DIV_LO +: 3];
      c.dec      = w[CB_DEC];
      c.sel      = w[CB_SEL_LO +: 4];
      c.force_ss = w[CB_FORCE];
      c.man_en   = w[CB_MAN_EN];
      return c;
   endfunction

   function automatic logic [31:0] cfg_pack(input cfg_t c);
      logic [31:0] w;
      w                  = '0;
      w[CB_MST]          = c.mst;
      w[CB_CPOL]         = c.cpol;
      w[CB_CPHA]         = c.cpha;
      w[CB_DIV_LO +: 3]  = c.div;
      w[CB_DEC]          = c.dec;
      w[CB_SEL_LO +: 4]  = c.sel;
      w[CB_FORCE]        = c.force_ss;
      w[CB_MAN_EN]       = c.man_en;
      return w;
   endfunction

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 128
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         full,
   output logic         empty
);
   localparam int AW = $clog2(DEPTH);

   generate
      if ((1 << AW) != DEPTH || DEPTH < 2) begin : g_bad_depth
         $error("spi_byte_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wr_ptr, rd_ptr, count;
   logic         do_push, do_pop;

   assign count   = wr_ptr - rd_ptr;
   assign full    = (count == (AW+1)'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rd_ptr[AW-1:0]];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr[AW-1:0]] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      end
   end

   // R7: occupancy never passes the depth, and a push into a full queue is lost
   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      count <= (AW+1)'(DEPTH));
   p_drop_when_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (count == $past(count)));

endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
   parameter int DIV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_code,
   output logic             tick
);
   localparam int CNT_W = (1 << DIV_W) - 1;

   generate
      if (DIV_W < 2 || DIV_W > 4) begin : g_bad_div
         $error("spi_baud_gen: DIV_W must lie between 2 and 4");
      end
   endgenerate

   logic [CNT_W-1:0] cnt, lim;
   logic [DIV_W-1:0] code_eff;

   always_comb begin
      code_eff = (div_code == '0) ? DIV_W'(1) : div_code;
      lim      = CNT_W'((32'd1 << code_eff) - 32'd1);
      tick     = run && (cnt == lim);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!run || tick)   cnt <= '0;
      else                     cnt <= cnt + 1'b1;
   end

   // R5: a half period is never shorter than two reference cycles
   p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
   import spi_fifo_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         active,
   input  logic         go_ok,
   input  logic         cpol,
   input  logic         cpha,
   input  logic         tick,
   input  logic         tx_empty,
   input  logic [W-1:0] tx_data,
   input  logic         rx_full,
   input  logic         miso,
   output logic         tx_pop,
   output logic         rx_push,
   output logic [W-1:0] rx_data,
   output logic         sclk_o,
   output logic         mosi_o,
   output logic         busy
);
   localparam int NEDGE = 2 * W;
   localparam int EW    = $clog2(NEDGE);

   generate
      if (W < 2) begin : g_bad_w
         $error("spi_shift_engine: W must be at least 2");
      end
   endgenerate

   eng_state_t   state;
   logic [EW-1:0] edge_cnt;
   logic [W-1:0]  tx_sh, rx_sh;
   logic          sclk_r, mosi_r;
   logic          start, last, lead;

   assign start   = active && go_ok && (state == ENG_IDLE) && !tx_empty && !rx_full;
   assign tx_pop  = start;
   assign last    = (edge_cnt == EW'(NEDGE - 1));
   assign lead    = !edge_cnt[0];
   assign rx_push = active && (state == ENG_XFER) && tick && last;
   assign rx_data = cpha ? {rx_sh[W-2:0], miso} : rx_sh;
   assign busy    = (state == ENG_XFER);
   assign sclk_o  = sclk_r;
   assign mosi_o  = mosi_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ENG_IDLE;
         edge_cnt <= '0;
         tx_sh    <= '0;
         rx_sh    <= '0;
         sclk_r   <= 1'b0;
         mosi_r   <= 1'b0;
      end else if (!active) begin
         state    <= ENG_IDLE;
         edge_cnt <= '0;
         sclk_r   <= cpol;
      end else begin
         case (state)
            ENG_IDLE: begin
               sclk_r <= cpol;
               if (start) begin
                  state    <= ENG_XFER;
                  edge_cnt <= '0;
                  if (!cpha) begin
                     mosi_r <= tx_data[W-1];
                     tx_sh  <= {tx_data[W-2:0], 1'b0};
                  end else begin
                     tx_sh  <= tx_data;
                  end
               end
            end
            ENG_XFER: begin
               if (tick) begin
                  sclk_r   <= ~sclk_r;
                  edge_cnt <= edge_cnt + 1'b1;
                  if (lead) begin
                     if (!cpha) begin
                        rx_sh <= {rx_sh[W-2:0], miso};
                     end else begin
                        mosi_r <= tx_sh[W-1];
                        tx_sh  <= {tx_sh[W-2:0], 1'b0};
                     end
                  end else begin
                     if (!cpha) begin
                        if (!last) begin
                           mosi_r <= tx_sh[W-1];
                           tx_sh  <= {tx_sh[W-2:0], 1'b0};
                        end
                     end else begin
                        rx_sh <= {rx_sh[W-2:0], miso};
                     end
                  end
                  if (last) state <= ENG_IDLE;
               end
            end
            default: state <= ENG_IDLE;
         endcase
      end
   end

   // R3: a popped byte always starts a shift, and after the final edge sclk rests at the polarity level
   p_pop_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |=> (state == ENG_XFER));
   p_end_at_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |=> (sclk_r == $past(cpol)));

endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
   import spi_fifo_pkg::*;
#(
   parameter int FIFO_DEPTH = 128,
   parameter int DATA_W     = 8,
   parameter int DIV_W      = 3,
   parameter int SS_W       = 4,
   parameter int ADDR_W     = 4,
   parameter int REG_W      = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [REG_W-1:0]  bus_wdata,
   input  logic              bus_rd,
   output logic [REG_W-1:0]  bus_rdata,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic [SS_W-1:0]   ss_n
);
   generate
      if (DATA_W != 8 || DIV_W != 3 || SS_W != 4 || ADDR_W != 4 || REG_W != 32) begin : g_bad_layout
         $error("spi_fifo_master: register layout fixes DATA_W=8 DIV_W=3 SS_W=4 ADDR_W=4 REG_W=32");
      end
   endgenerate

   cfg_t              cfg_q;
   logic              en_q, go_q;
   logic              cpol_l, cpha_l;
   logic [DIV_W-1:0]  div_l;
   logic              active, go_ok, ss_active;
   logic              wr_cfg, wr_en, tx_push, rx_pop, rd_rx;
   logic              tx_pop, tx_empty, rx_push, rx_full, rx_empty;
   logic [DATA_W-1:0] tx_head, rx_head, rx_in;
   logic              eng_sclk, eng_busy, tick;
   logic              txf_unused;
   logic              unused_wbits;

   assign unused_wbits = ^{bus_wdata[REG_W-1:17], bus_wdata[8:6]};

   assign wr_cfg  = bus_wr && (bus_addr == ADDR_CFG);
   assign wr_en   = bus_wr && (bus_addr == ADDR_EN);
   assign tx_push = bus_wr && (bus_addr == ADDR_TX);
   assign rd_rx   = bus_rd && (bus_addr == ADDR_RX);
   assign rx_pop  = rd_rx && !rx_empty;

   assign active  = en_q && cfg_q.mst;
   assign go_ok   = cfg_q.man_en ? go_q : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= CFG_RESET;
         en_q  <= 1'b0;
         go_q  <= 1'b0;
      end else begin
         if (wr_cfg) cfg_q <= cfg_unpack(bus_wdata);
         if (wr_en)  en_q  <= bus_wdata[0];
         if (wr_cfg && bus_wdata[CB_MAN_GO])             go_q <= 1'b1;
         else if (!cfg_q.man_en || (!eng_busy && tx_empty)) go_q <= 1'b0;
      end
   end

   // timing fields follow the register only while the core is disabled
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpol_l <= CFG_RESET.cpol;
         cpha_l <= CFG_RESET.cpha;
         div_l  <= CFG_RESET.div;
      end else if (!active) begin
         cpol_l <= cfg_q.cpol;
         cpha_l <= cfg_q.cpha;
         div_l  <= cfg_q.div;
      end
   end

   always_comb begin
      case (bus_addr)
         ADDR_CFG: bus_rdata = cfg_pack(cfg_q);
         ADDR_EN:  bus_rdata = {{(REG_W-1){1'b0}}, en_q};
         ADDR_RX:  bus_rdata = rx_empty ? '0 : {{(REG_W-DATA_W){1'b0}}, rx_head};
         default:  bus_rdata = '0;
      endcase
   end

   spi_byte_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (tx_push),
      .wdata (bus_wdata[DATA_W-1:0]),
      .pop   (tx_pop),
      .rdata (tx_head),
      .full  (txf_unused),
      .empty (tx_empty)
   );

   spi_byte_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rx_push),
      .wdata (rx_in),
      .pop   (rx_pop),
      .rdata (rx_head),
      .full  (rx_full),
      .empty (rx_empty)
   );

   spi_baud_gen #(.DIV_W(DIV_W)) u_baud (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (eng_busy),
      .div_code (div_l),
      .tick     (tick)
   );

   spi_shift_engine #(.W(DATA_W)) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (active),
      .go_ok    (go_ok),
      .cpol     (cpol_l),
      .cpha     (cpha_l),
      .tick     (tick),
      .tx_empty (tx_empty),
      .tx_data  (tx_head),
      .rx_full  (rx_full),
      .miso     (miso),
      .tx_pop   (tx_pop),
      .rx_push  (rx_push),
      .rx_data  (rx_in),
      .sclk_o   (eng_sclk),
      .mosi_o   (mosi),
      .busy     (eng_busy)
   );

   assign sclk      = active ? eng_sclk : cfg_q.cpol;
   assign ss_active = eng_busy || (active && go_ok && !tx_empty);

   generate
      for (genvar i = 0; i < SS_W; i++) begin : g_ss
         assign ss_n[i] = (cfg_q.force_ss || ss_active) ? cfg_q.sel[i] : 1'b1;
      end
   endgenerate

   // R6: the latched timing fields stay put for as long as the core is enabled
   p_frozen_timing_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active)) |-> (cpol_l == $past(cpol_l) && cpha_l == $past(cpha_l)
                                     && div_l == $past(div_l)));
   // R10: without a start permission an idle engine stays idle
   p_manual_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.man_en && !go_q && !eng_busy) |=> !eng_busy);
   // R9: no shifting starts while disabled
   p_idle_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !tx_pop || active);

endmodule

// File: tb/tb_spi_fifo_master.sv
`timescale 1ns/1ps
module tb_spi_fifo_master;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [3:0]  bus_addr;
   logic        bus_wr, bus_rd;
   logic [31:0] bus_wdata, bus_rdata;
   logic        sclk, mosi, miso;
   logic [3:0]  ss_n;

   always #5 clk = ~clk;

   spi_fifo_master dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
   );

   int n_checks = 0;
   int n_errors = 0;

   // device model state
   logic       slv_on = 1'b0;
   logic       m_cpol = 1'b0, m_cpha = 1'b0;
   logic [7:0] sh;
   int         bi = 0;
   int         lib = 0;
   int         cap_n = 0;
   logic [7:0] cap [0:511];
   logic [7:0] resp_cur;
   longint     t_lead = 0, meas = 0;

   logic [7:0] tx_log [0:511];
   int         tx_n = 0;
   int         rx_k = 0;

   function automatic logic [7:0] resp(input int k);
      return 8'(k * 29 + 90) ^ 8'h33;
   endfunction

   function automatic logic [31:0] mkcfg(input logic mst, input logic cpol, input logic cpha,
                                         input logic [2:0] dv, input logic dec, input logic [3:0] sel,
                                         input logic frc, input logic man, input logic go);
      logic [31:0] w = '0;
      w[0] = mst; w[1] = cpol; w[2] = cpha; w[5:3] = dv; w[9] = dec;
      w[13:10] = sel; w[14] = frc; w[15] = man; w[16] = go;
      return w;
   endfunction

   task automatic finish_byte();
      cap[cap_n] = sh;
      cap_n++;
      bi = 0;
      lib = 0;
      resp_cur = resp(cap_n);
   endtask

   always @(sclk) begin
      if (slv_on) begin
         if (sclk != m_cpol) begin
            if (lib > 0) meas = $time - t_lead;
            t_lead = $time;
            lib++;
            if (!m_cpha) begin
               sh = {sh[6:0], mosi};
               bi++;
            end else begin
               miso <= resp_cur[3'(7 - bi)];
            end
         end else begin
            if (!m_cpha) begin
               if (bi == 8) begin
                  finish_byte();
                  miso <= resp_cur[7];
               end else begin
                  miso <= resp_cur[3'(7 - bi)];
               end
            end else begin
               sh = {sh[6:0], mosi};
               bi++;
               if (bi == 8) finish_byte();
            end
         end
      end
   end

   task automatic slave_reset();
      bi = 0;
      lib = 0;
      resp_cur = resp(cap_n);
      miso <= resp_cur[7];
   endtask

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #2;
      d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic send(input logic [7:0] b);
      wr(4'h8, {24'h0, b});
      tx_log[tx_n] = b;
      tx_n++;
   endtask

   task automatic wait_caps(input int n);
      int t = 0;
      while (cap_n < n && t < 40000) begin
         @(posedge clk);
         t++;
      end
      repeat (6) @(posedge clk);
   endtask

   task automatic configure(input logic cpol, input logic cpha, input logic [2:0] dv,
                            input logic man, input logic frc, input logic [3:0] sel);
      wr(4'h4, 32'h0);
      slv_on = 1'b0;
      wr(4'h0, mkcfg(1'b1, cpol, cpha, dv, 1'b0, sel, frc, man, 1'b0));
      m_cpol = cpol;
      m_cpha = cpha;
      slave_reset();
      slv_on = 1'b1;
      wr(4'h4, 32'h1);
   endtask

   // compare what the device saw with what was sent, then drain the receive queue
   task automatic verify(input int from, input string req);
      logic [31:0] d;
      chk(cap_n == tx_n, req, 32'(cap_n), 32'(tx_n));
      for (int k = from; k < cap_n; k++)
         chk(cap[k] == tx_log[k], req, {24'h0, cap[k]}, {24'h0, tx_log[k]});
      while (rx_k < cap_n) begin
         rd(4'hC, d);
         chk(d == {24'h0, resp(rx_k)}, req, d, {24'h0, resp(rx_k)});
         rx_k++;
      end
   endtask

   initial begin
      #(10 * 150000);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int base;
      void'($urandom(32'd1234));
      rst_n = 1'b0;
      bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
      miso = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(4'h0, d);  chk(d == 32'h0000_3C09, "R1 cfg", d, 32'h0000_3C09);
      rd(4'h4, d);  chk(d == 32'h0, "R1 en", d, 32'h0);
      chk(ss_n == 4'hF, "R1 ss_n", {28'h0, ss_n}, 32'hF);
      chk(sclk == 1'b0, "R1 sclk", {31'h0, sclk}, 32'h0);

      // R2 field readback, bit 16 reads 0
      wr(4'h0, mkcfg(1'b1, 1'b1, 1'b0, 3'd5, 1'b1, 4'hA, 1'b1, 1'b1, 1'b1));
      rd(4'h0, d);
      chk(d == mkcfg(1'b1, 1'b1, 1'b0, 3'd5, 1'b1, 4'hA, 1'b1, 1'b1, 1'b0), "R2 readback", d,
          mkcfg(1'b1, 1'b1, 1'b0, 3'd5, 1'b1, 4'hA, 1'b1, 1'b1, 1'b0));
      rd(4'h8, d);  chk(d == 32'h0, "R2 tx reads 0", d, 32'h0);

      // R8 empty receive read
      rd(4'hC, d);  chk(d == 32'h0, "R8 empty rx", d, 32'h0);

      // R3 R4: all four modes with random bytes and divisors
      for (int m = 0; m < 4; m++) begin
         base = cap_n;
         configure(m[1], m[0], 3'(1 + $urandom % 3), 1'b0, 1'b0, 4'hE);
         for (int b = 0; b < 3; b++) send(8'($urandom));
         wait_caps(tx_n);
         verify(base, m[0] ? "R4 phase1 R3" : "R4 phase0 R3");
      end

      // directed bytes for bit order
      base = cap_n;
      configure(1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 4'hE);
      send(8'h80); send(8'h01); send(8'h00); send(8'hFF);
      wait_caps(tx_n);
      verify(base, "R3 msb first");

      // R5 divisor timing
      for (int c = 0; c < 4; c++) begin
         logic [2:0] code;
         longint expt;
         code = (c == 0) ? 3'd0 : (c == 1) ? 3'd1 : (c == 2) ? 3'd3 : 3'd7;
         expt = longint'(2 << ((code == 0) ? 1 : code)) * 10;
         base = cap_n;
         configure(1'b0, 1'b1, code, 1'b0, 1'b0, 4'hE);
         send(8'($urandom));
         wait_caps(tx_n);
         chk(meas == expt, "R5 period", 32'(meas), 32'(expt));
         verify(base, "R5 data");
      end

      // R6 polarity change while enabled has no effect until disabled
      base = cap_n;
      configure(1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 4'hE);
      wr(4'h0, mkcfg(1'b1, 1'b1, 1'b1, 3'd2, 1'b0, 4'hE, 1'b0, 1'b0, 1'b0));
      chk(sclk == 1'b0, "R6 frozen idle", {31'h0, sclk}, 32'h0);
      send(8'hA5);
      wait_caps(tx_n);
      verify(base, "R6 old mode still used");
      slv_on = 1'b0;
      wr(4'h4, 32'h0);
      chk(sclk == 1'b1, "R6 disabled level", {31'h0, sclk}, 32'h1);

      // R9 master enable gates traffic
      base = cap_n;
      wr(4'h0, mkcfg(1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 4'hE, 1'b0, 1'b0, 1'b0));
      m_cpol = 1'b0; m_cpha = 1'b0;
      slave_reset();
      slv_on = 1'b1;
      wr(4'h4, 32'h1);
      send(8'h3C);
      repeat (200) @(posedge clk);
      chk(cap_n == base, "R9 held without master", 32'(cap_n), 32'(base));
      wr(4'h0, mkcfg(1'b1, 1'b0, 1'b0, 3'd1, 1'b0, 4'hE, 1'b0, 1'b0, 1'b0));
      wait_caps(tx_n);
      verify(base, "R9 runs with master");

      // R10 R11 manual start and automatic select
      base = cap_n;
      configure(1'b0, 1'b0, 3'd2, 1'b1, 1'b0, 4'hE);
      send(8'h12); send(8'hED);
      repeat (300) @(posedge clk);
      chk(cap_n == base, "R10 held", 32'(cap_n), 32'(base));
      chk(ss_n == 4'hF, "R11 idle deselect", {28'h0, ss_n}, 32'hF);
      wr(4'h0, mkcfg(1'b1, 1'b0, 1'b0, 3'd2, 1'b0, 4'hE, 1'b0, 1'b1, 1'b1));
      repeat (10) @(posedge clk);
      #1;
      chk(ss_n == 4'hE, "R11 select during shift", {28'h0, ss_n}, 32'hE);
      wait_caps(tx_n);
      chk(ss_n == 4'hF, "R11 deselect after", {28'h0, ss_n}, 32'hF);
      rd(4'h0, d);
      chk(d[16] == 1'b0, "R10 start self-clears", {31'h0, d[16]}, 32'h0);
      verify(base, "R10 released");
      base = cap_n;
      send(8'h77);
      repeat (300) @(posedge clk);
      chk(cap_n == base, "R10 permission ended", 32'(cap_n), 32'(base));
      wr(4'h0, mkcfg(1'b1, 1'b0, 1'b0, 3'd2, 1'b0, 4'hE, 1'b0, 1'b1, 1'b1));
      wait_caps(tx_n);
      verify(base, "R10 second start");

      // R11 forced select
      slv_on = 1'b0;
      wr(4'h4, 32'h0);
      wr(4'h0, mkcfg(1'b1, 1'b0, 1'b0, 3'd1, 1'b1, 4'h5, 1'b1, 1'b0, 1'b0));
      chk(ss_n == 4'h5, "R11 forced", {28'h0, ss_n}, 32'h5);

      // R7 queue depth and dropped writes
      base = cap_n;
      wr(4'h0, mkcfg(1'b1, 1'b0, 1'b0, 3'd1, 1'b0, 4'hE, 1'b0, 1'b0, 1'b0));
      m_cpol = 1'b0; m_cpha = 1'b0;
      slave_reset();
      for (int i = 0; i < 130; i++) begin
         logic [7:0] b;
         b = 8'($urandom);
         if (i < 128) send(b);
         else wr(4'h8, {24'h0, b});
      end
      slv_on = 1'b1;
      wr(4'h4, 32'h1);
      wait_caps(base + 130);
      repeat (200) @(posedge clk);
      chk(cap_n == base + 128, "R7 depth", 32'(cap_n), 32'(base + 128));
      verify(base, "R7 contents");
      rd(4'hC, d);  chk(d == 32'h0, "R8 empty after drain", d, 32'h0);

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule